// File: doc/BRIEF.md
# Region-Based DRAM Access Guard

This block sits between requesters and a DRAM controller and decides, request by request, whether an access may proceed. It keeps a table of 32 address windows. Each window has a lower bound, an upper bound and a three-bit permission code for each of 16 requester domains. A request carries a domain number, a secure/non-secure flag, a read/write flag and a 40-bit physical address. The guard converts the address into 64 KiB units counted from the DRAM base at 0x4000_0000. It compares that value against every window in parallel and returns a registered allow/deny verdict one clock later.

Software programs the table through a plain 32-bit register port. Writes take effect on the clock edge and reads return data in the same cycle. Each window has a one-way lock. Once the lock is set, every register of that window stays frozen until reset. Blocking wins: when several windows cover an address, one denying window is enough to block the request.

Top module: `mem_guard`

## Requirements
- R1: After reset every table register reads zero, no window is locked, and a request at the DRAM base (unit 0, where every reset window matches with code 0) is allowed.
- R2: Register map, with cfg_addr bits [1:0] ignored: window r lower bound at 0x100+4r, upper bound at 0x200+4r, permission word for domain group g at 0x300+0x100g+4r. Bounds and permission words keep bits [23:0] only. All other bits read zero, except bit 31 of a group-0 word, which reads back the window's lock.
- R3: Any offset outside the map, including window slots 32 to 63 within a page and pages 0 and 5 to 15, reads zero and ignores writes without disturbing any window.
- R4: A request at or above the base is compared as (addr − 0x4000_0000) >> 16. A window matches when lower ≤ value ≤ upper, with both bounds inclusive.
- R5: Permission code meaning (S = secure, N = non-secure): 0 all allowed; 1 S read/write only; 2 S read/write plus N read; 3 S read/write plus N write; 4 reads only for both; 5 nothing; 6 S read plus N read/write; 7 nothing.
- R6: Domain d takes its code from the permission word of group d/8, at bits [3(d%8)+2 : 3(d%8)].
- R7: A request is denied when any matching window's code denies it. A request that matches no window is allowed.
- R8: A request whose address is below 0x4000_0000 is allowed whatever the table holds.
- R9: rsp_valid is high exactly one cycle after req_valid, and rsp_allow is low whenever rsp_valid is low.
- R10: Writing a group-0 permission word with bit 31 set stores that word and locks the window. From then on, writes to any of that window's registers are ignored until reset, and the lock itself cannot be cleared.
- R11: A request and a table write in the same cycle: the request is judged against the table as it stood before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 12 | Register byte offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for cfg_addr, same cycle |
| req_valid | input | 1 | Request present this cycle |
| req_domain | input | 4 | Requester domain number |
| req_secure | input | 1 | 1 = secure access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 40 | Physical byte address |
| rsp_valid | output | 1 | Verdict present (one cycle after request) |
| rsp_allow | output | 1 | 1 = request allowed |

## Verification
A table write and a lookup can fall on the same clock edge. The write updates the window registers at that edge, while the verdict registered at the same edge is computed from the table the lookup saw before it. The bench drives a permission write that turns a matching window from open to blocked in the very cycle a request for that window is presented. It expects an allow for that request and a deny for an identical request one cycle later. A second overlap, a locking write followed at once by further writes, is judged by reading the window back and probing it.

// File: rtl/mg_pkg.sv
package mg_pkg;
  localparam int unsigned MG_REGIONS = 32;
  localparam int unsigned MG_DOMAINS = 16;
  localparam int unsigned MG_GROUP   = 8;
  localparam int unsigned MG_CODE_W  = 3;
  localparam int unsigned MG_ADDR_W  = 40;
  localparam int unsigned MG_GRAN    = 16;
  localparam int unsigned MG_CFG_AW  = 12;

  typedef enum logic [MG_CODE_W-1:0] {
    PC_OPEN     = 3'd0,
    PC_SEC_ONLY = 3'd1,
    PC_SEC_NSR  = 3'd2,
    PC_SEC_NSW  = 3'd3,
    PC_RD_ONLY  = 3'd4,
    PC_BLOCK    = 3'd5,
    PC_SR_NSRW  = 3'd6,
    PC_RSVD     = 3'd7
  } perm_code_e;

  // Decide one access against one permission code.
  function automatic logic perm_allows(input logic [MG_CODE_W-1:0] code,
                                       input logic sec, input logic wr);
    logic ok;
    case (perm_code_e'(code))
      PC_OPEN:     ok = 1'b1;
      PC_SEC_ONLY: ok = sec;
      PC_SEC_NSR:  ok = sec | ~wr;
      PC_SEC_NSW:  ok = sec | wr;
      PC_RD_ONLY:  ok = ~wr;
      PC_SR_NSRW:  ok = sec ? ~wr : 1'b1;
      default:     ok = 1'b0;
    endcase
    return ok;
  endfunction
endpackage

// File: rtl/mg_regfile.sv
module mg_regfile #(
  parameter int NUM_REGIONS = 32,
  parameter int NUM_GROUPS  = 2,
  parameter int FIELD_W     = 24,
  parameter int PERM_W      = 24
) (
  input  logic                                         clk,
  input  logic                                         rst_n,
  input  logic                                         cfg_wr,
  input  logic [mg_pkg::MG_CFG_AW-1:0]                 cfg_addr,
  input  logic [31:0]                                  cfg_wdata,
  output logic [31:0]                                  cfg_rdata,
  output logic [NUM_REGIONS-1:0][FIELD_W-1:0]          start_q,
  output logic [NUM_REGIONS-1:0][FIELD_W-1:0]          end_q,
  output logic [NUM_REGIONS-1:0][NUM_GROUPS*PERM_W-1:0] perm_q,
  output logic [NUM_REGIONS-1:0]                       lock_q
);
  localparam int RIDX_W   = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1;
  localparam int LOCK_BIT = 31;
  localparam int PERM_PG  = 3;

  logic [3:0]        page;
  logic [5:0]        slot;
  logic [3:0]        grp;
  logic              slot_ok, page_start, page_end, page_perm;
  logic [RIDX_W-1:0] rsel;

  assign page       = cfg_addr[11:8];
  assign slot       = cfg_addr[7:2];
  assign slot_ok    = int'(slot) < NUM_REGIONS;
  assign rsel       = slot[RIDX_W-1:0];
  assign grp        = page - 4'(PERM_PG);
  assign page_start = (page == 4'h1);
  assign page_end   = (page == 4'h2);
  assign page_perm  = (int'(page) >= PERM_PG) && (int'(page) < PERM_PG + NUM_GROUPS);

  for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_row
    logic [FIELD_W-1:0]           s_r, e_r;
    logic [NUM_GROUPS*PERM_W-1:0] p_r;
    logic                         l_r;
    logic                         wr_row;

    assign wr_row = cfg_wr && slot_ok && (int'(rsel) == r) && !l_r;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s_r <= '0;
        e_r <= '0;
        p_r <= '0;
        l_r <= 1'b0;
      end else if (wr_row) begin
        if (page_start) s_r <= cfg_wdata[FIELD_W-1:0];
        if (page_end)   e_r <= cfg_wdata[FIELD_W-1:0];
        for (int g = 0; g < NUM_GROUPS; g++)
          if (page_perm && int'(grp) == g) p_r[g*PERM_W +: PERM_W] <= cfg_wdata[PERM_W-1:0];
        if (page_perm && grp == 4'd0 && cfg_wdata[LOCK_BIT]) l_r <= 1'b1;
      end
    end

    assign start_q[r] = s_r;
    assign end_q[r]   = e_r;
    assign perm_q[r]  = p_r;
    assign lock_q[r]  = l_r;
  end

  always_comb begin
    cfg_rdata = '0;
    if (slot_ok) begin
      if (page_start) cfg_rdata[FIELD_W-1:0] = start_q[rsel];
      if (page_end)   cfg_rdata[FIELD_W-1:0] = end_q[rsel];
      for (int g = 0; g < NUM_GROUPS; g++)
        if (page_perm && int'(grp) == g) cfg_rdata[PERM_W-1:0] = perm_q[rsel][g*PERM_W +: PERM_W];
      if (page_perm && grp == 4'd0) cfg_rdata[LOCK_BIT] = lock_q[rsel];
    end
  end
endmodule

// File: rtl/mg_region_check.sv
module mg_region_check #(
  parameter int FIELD_W     = 24,
  parameter int NUM_DOMAINS = 16,
  parameter int DOM_W       = 4
) (
  input  logic [FIELD_W-1:0]                         lo,
  input  logic [FIELD_W-1:0]                         hi,
  input  logic [FIELD_W-1:0]                         units,
  input  logic [NUM_DOMAINS*mg_pkg::MG_CODE_W-1:0]   codes,
  input  logic [DOM_W-1:0]                           dom,
  input  logic                                       sec,
  input  logic                                       wr,
  output logic                                       hit,
  output logic                                       deny
);
  logic [mg_pkg::MG_CODE_W-1:0] code;

  assign code = codes[int'(dom)*mg_pkg::MG_CODE_W +: mg_pkg::MG_CODE_W];
  assign hit  = (lo <= units) && (units <= hi);
  assign deny = !mg_pkg::perm_allows(code, sec, wr);
endmodule

// File: rtl/mem_guard.sv
module mem_guard #(
  parameter int              NUM_REGIONS = mg_pkg::MG_REGIONS,
  parameter int              NUM_DOMAINS = mg_pkg::MG_DOMAINS,
  parameter int              GROUP_SIZE  = mg_pkg::MG_GROUP,
  parameter int              ADDR_W      = mg_pkg::MG_ADDR_W,
  parameter int              GRAN_BITS   = mg_pkg::MG_GRAN,
  parameter longint unsigned DRAM_BASE   = 64'h4000_0000
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cfg_wr,
  input  logic [mg_pkg::MG_CFG_AW-1:0] cfg_addr,
  input  logic [31:0]                  cfg_wdata,
  output logic [31:0]                  cfg_rdata,
  input  logic                         req_valid,
  input  logic [$clog2(NUM_DOMAINS)-1:0] req_domain,
  input  logic                         req_secure,
  input  logic                         req_write,
  input  logic [ADDR_W-1:0]            req_addr,
  output logic                         rsp_valid,
  output logic                         rsp_allow
);
  localparam int NUM_GROUPS = NUM_DOMAINS / GROUP_SIZE;
  localparam int PERM_W     = GROUP_SIZE * mg_pkg::MG_CODE_W;
  localparam int FIELD_W    = ADDR_W - GRAN_BITS;
  localparam int DOM_W      = $clog2(NUM_DOMAINS);
  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(DRAM_BASE);

  // Offset from the DRAM base in granule units.
  function automatic logic [FIELD_W-1:0] to_units(input logic [ADDR_W-1:0] a);
    logic [ADDR_W-1:0] diff;
    diff = a - BASE_A;
    return diff[ADDR_W-1:GRAN_BITS];
  endfunction

  logic [NUM_REGIONS-1:0][FIELD_W-1:0]           start_q, end_q;
  logic [NUM_REGIONS-1:0][NUM_GROUPS*PERM_W-1:0] perm_q;
  logic [NUM_REGIONS-1:0]                        lock_q;
  logic [NUM_REGIONS-1:0]                        hit_vec, deny_vec;
  logic [FIELD_W-1:0]                            req_units;
  logic                                          below_base, allow_c;

  mg_regfile #(
    .NUM_REGIONS(NUM_REGIONS), .NUM_GROUPS(NUM_GROUPS),
    .FIELD_W(FIELD_W), .PERM_W(PERM_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .start_q(start_q), .end_q(end_q), .perm_q(perm_q), .lock_q(lock_q)
  );

  assign below_base = req_addr < BASE_A;
  assign req_units  = to_units(req_addr);

  for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_chk
    mg_region_check #(
      .FIELD_W(FIELD_W), .NUM_DOMAINS(NUM_DOMAINS), .DOM_W(DOM_W)
    ) u_rc (
      .lo(start_q[r]), .hi(end_q[r]), .units(req_units), .codes(perm_q[r]),
      .dom(req_domain), .sec(req_secure), .wr(req_write),
      .hit(hit_vec[r]), .deny(deny_vec[r])
    );
  end

  assign allow_c = below_base || ((hit_vec & deny_vec) == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_allow <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      rsp_allow <= req_valid && allow_c;
    end
  end
endmodule

// File: rtl/mg_guard_checker.sv
module mg_guard_checker #(
  parameter int NUM_REGIONS = 32,
  parameter int FIELD_W     = 24,
  parameter int PERM_BITS   = 48
) (
  input logic                                  clk,
  input logic                                  rst_n,
  input logic                                  req_valid,
  input logic                                  rsp_valid,
  input logic                                  rsp_allow,
  input logic                                  below_base,
  input logic [NUM_REGIONS-1:0]                hit_vec,
  input logic [NUM_REGIONS-1:0]                deny_vec,
  input logic [NUM_REGIONS-1:0]                lock_q,
  input logic [NUM_REGIONS-1:0][FIELD_W-1:0]   start_q,
  input logic [NUM_REGIONS-1:0][FIELD_W-1:0]   end_q,
  input logic [NUM_REGIONS-1:0][PERM_BITS-1:0] perm_q
);
  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n) req_valid |=> rsp_valid); // R9
  AST_RSP_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !req_valid |=> !rsp_valid); // R9
  AST_ALLOW_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n) !rsp_valid |-> !rsp_allow); // R9
  AST_DENY_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !below_base && ((hit_vec & deny_vec) != '0)) |=> !rsp_allow); // R7
  AST_NO_MATCH_ALLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !below_base && (hit_vec == '0)) |=> rsp_allow); // R7
  AST_BELOW_BASE_ALLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && below_base) |=> rsp_allow); // R8

  for (genvar i = 0; i < NUM_REGIONS; i++) begin : g_lock
    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n) $past(lock_q[i]) |-> lock_q[i]); // R10
    AST_LOCK_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      $past(lock_q[i]) |-> ($stable(start_q[i]) && $stable(end_q[i]) && $stable(perm_q[i]))); // R10
  end
endmodule

bind mem_guard mg_guard_checker #(
  .NUM_REGIONS(NUM_REGIONS), .FIELD_W(FIELD_W), .PERM_BITS(NUM_GROUPS*PERM_W)
) u_guard_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .rsp_valid(rsp_valid),
  .rsp_allow(rsp_allow), .below_base(below_base), .hit_vec(hit_vec),
  .deny_vec(deny_vec), .lock_q(lock_q), .start_q(start_q), .end_q(end_q),
  .perm_q(perm_q)
);

// File: tb/test_mem_guard.sv
module test_mem_guard;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [11:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        req_valid = 1'b0;
  logic [3:0]  req_domain = '0;
  logic        req_secure = 1'b0;
  logic        req_write = 1'b0;
  logic [39:0] req_addr = '0;
  logic        rsp_valid, rsp_allow;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  always #2.5 clk = ~clk;

  mem_guard i_mem_guard (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req_valid(req_valid),
    .req_domain(req_domain), .req_secure(req_secure), .req_write(req_write),
    .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_allow(rsp_allow)
  );

  function automatic logic [11:0] a_lo(input int r);  return 12'(32'h100 + 4*r); endfunction
  function automatic logic [11:0] a_hi(input int r);  return 12'(32'h200 + 4*r); endfunction
  function automatic logic [11:0] a_pm(input int r, input int g);
    return 12'(32'h300 + 32'h100*g + 4*r);
  endfunction
  function automatic logic [39:0] at_unit(input int u);
    return 40'h00_4000_0000 + (40'(u) << 16);
  endfunction
  // Allowed-access table: per code, bits {S rd, S wr, N rd, N wr}.
  function automatic logic ref_allow(input int code, input logic sec, input logic wr);
    logic [3:0] t [8] = '{4'b1111, 4'b1100, 4'b1110, 4'b1101, 4'b1010, 4'b0000, 4'b1011, 4'b0000};
    int pos;
    pos = 3 - (int'(!sec) * 2 + int'(wr));
    return t[code][pos];
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    cfg_addr = a;
    #1 d = cfg_rdata;
  endtask

  task automatic probe(input int dom, input logic sec, input logic wr,
                       input logic [39:0] addr, output logic ok);
    @(negedge clk);
    req_valid = 1'b1; req_domain = 4'(dom); req_secure = sec; req_write = wr; req_addr = addr;
    @(negedge clk);
    req_valid = 1'b0;
    ok = rsp_allow;
  endtask

  task automatic t_reset;
    logic [31:0] d; logic ok;
    rd_reg(a_lo(0), d);     check("R1 start0 reset", d, 0);
    rd_reg(a_hi(31), d);    check("R1 end31 reset", d, 0);
    rd_reg(a_pm(0, 0), d);  check("R1 perm0 g0 reset", d, 0);
    rd_reg(a_pm(31, 1), d); check("R1 perm31 g1 reset", d, 0);
    probe(0, 1'b0, 1'b1, at_unit(0), ok); check("R1 unit0 allowed", 32'(ok), 1);
    probe(0, 1'b0, 1'b1, at_unit(5), ok); check("R7 no match allowed", 32'(ok), 1);
  endtask

  task automatic t_map;
    logic [31:0] d;
    wr_reg(a_lo(5), 32'hFFFF_FFFF);    rd_reg(a_lo(5), d);    check("R2 start width", d, 32'h00FF_FFFF);
    wr_reg(a_hi(5), 32'hABCD_EF12);    rd_reg(a_hi(5), d);    check("R2 end width", d, 32'h00CD_EF12);
    wr_reg(a_pm(5, 1), 32'h8FFF_FFFF); rd_reg(a_pm(5, 1), d); check("R2 group1 bit31 zero", d, 32'h00FF_FFFF);
    wr_reg(a_lo(5), 32'h100);          rd_reg(a_lo(5), d);    check("R2 still writable", d, 32'h100);
    wr_reg(a_hi(5), 32'h1FF);
    wr_reg(a_pm(5, 1), 0);
  endtask

  task automatic t_outside;
    logic [31:0] d;
    wr_reg(12'h500, 32'hFFFF_FFFF); rd_reg(12'h500, d); check("R3 page5 reads zero", d, 0);
    wr_reg(12'h180, 32'h55);        rd_reg(12'h180, d); check("R3 slot32 reads zero", d, 0);
    rd_reg(a_lo(0), d);             check("R3 slot32 no alias", d, 0);
    wr_reg(12'h004, 32'h77);        rd_reg(12'h004, d); check("R3 page0 reads zero", d, 0);
  endtask

  task automatic t_codes;
    logic ok;
    for (int c = 0; c < 8; c++) begin
      wr_reg(a_pm(5, 0), 32'(c) << 9);
      for (int k = 0; k < 4; k++) begin
        probe(3, k[1], k[0], at_unit(32'h100), ok);
        check($sformatf("R5 code%0d sec%0d wr%0d", c, k[1], k[0]), 32'(ok),
              32'(ref_allow(c, k[1], k[0])));
      end
    end
  endtask

  task automatic t_domain;
    logic ok;
    wr_reg(a_pm(5, 0), 0);
    wr_reg(a_pm(5, 1), 32'(5) << 9);
    probe(3, 1'b1, 1'b0, at_unit(32'h100), ok);  check("R6 domain3 open", 32'(ok), 1);
    probe(11, 1'b1, 1'b0, at_unit(32'h100), ok); check("R6 domain11 blocked", 32'(ok), 0);
    probe(10, 1'b1, 1'b0, at_unit(32'h100), ok); check("R6 domain10 open", 32'(ok), 1);
    probe(12, 1'b1, 1'b0, at_unit(32'h100), ok); check("R6 domain12 open", 32'(ok), 1);
    wr_reg(a_pm(5, 1), 0);
  endtask

  task automatic t_range;
    logic ok;
    wr_reg(a_lo(6), 32'h10); wr_reg(a_hi(6), 32'h20);
    wr_reg(a_pm(6, 0), 32'h00B6_DB6D); wr_reg(a_pm(6, 1), 32'h00B6_DB6D);
    probe(0, 1'b1, 1'b0, at_unit(32'h10) - 1, ok); check("R4 below start", 32'(ok), 1);
    probe(0, 1'b1, 1'b0, at_unit(32'h10), ok);     check("R4 start inclusive", 32'(ok), 0);
    probe(0, 1'b1, 1'b0, at_unit(32'h21) - 1, ok); check("R4 end inclusive", 32'(ok), 0);
    probe(0, 1'b1, 1'b0, at_unit(32'h21), ok);     check("R4 above end", 32'(ok), 1);
  endtask

  task automatic t_overlap;
    logic ok;
    wr_reg(a_lo(8), 32'h180); wr_reg(a_hi(8), 32'h180); wr_reg(a_pm(8, 0), 32'h00B6_DB6D);
    probe(2, 1'b1, 1'b0, at_unit(32'h180), ok); check("R7 one denier blocks", 32'(ok), 0);
    probe(2, 1'b1, 1'b0, at_unit(32'h150), ok); check("R7 open only allows", 32'(ok), 1);
  endtask

  task automatic t_below;
    logic ok;
    wr_reg(a_hi(9), 32'hFF_FFFF);
    wr_reg(a_pm(9, 0), 32'h00B6_DB6D); wr_reg(a_pm(9, 1), 32'h00B6_DB6D);
    probe(1, 1'b0, 1'b1, 40'h00_3FFF_FFFF, ok); check("R8 below base allowed", 32'(ok), 1);
    probe(1, 1'b0, 1'b1, 40'h00_4000_0000, ok); check("R8 at base checked", 32'(ok), 0);
    wr_reg(a_pm(9, 0), 0); wr_reg(a_pm(9, 1), 0);
  endtask

  task automatic t_timing;
    @(negedge clk);
    check("R9 idle valid low", 32'(rsp_valid), 0);
    check("R9 idle allow low", 32'(rsp_allow), 0);
    req_valid = 1'b1; req_domain = 0; req_secure = 1'b1; req_write = 1'b0; req_addr = at_unit(32'h900);
    #1 check("R9 not same cycle", 32'(rsp_valid), 0);
    @(negedge clk);
    req_valid = 1'b0;
    check("R9 valid next cycle", 32'(rsp_valid), 1);
    check("R9 allow next cycle", 32'(rsp_allow), 1);
    @(negedge clk);
    check("R9 valid drops", 32'(rsp_valid), 0);
    check("R9 allow drops", 32'(rsp_allow), 0);
  endtask

  task automatic t_same_cycle;
    logic ok;
    wr_reg(a_lo(7), 32'h300); wr_reg(a_hi(7), 32'h300); wr_reg(a_pm(7, 0), 0);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = a_pm(7, 0); cfg_wdata = 32'h5;
    req_valid = 1'b1; req_domain = 0; req_secure = 1'b1; req_write = 1'b1; req_addr = at_unit(32'h300);
    @(negedge clk);
    cfg_wr = 1'b0; req_valid = 1'b0;
    check("R11 old table used", 32'(rsp_allow), 1);
    probe(0, 1'b1, 1'b1, at_unit(32'h300), ok); check("R11 new table next", 32'(ok), 0);
  endtask

  task automatic t_lock;
    logic [31:0] d; logic ok;
    wr_reg(a_lo(10), 32'h400); wr_reg(a_hi(10), 32'h400); wr_reg(a_pm(10, 1), 0);
    wr_reg(a_pm(10, 0), 32'h8000_0005);
    rd_reg(a_pm(10, 0), d); check("R10 lock reads back", d, 32'h8000_0005);
    wr_reg(a_pm(10, 0), 0);
    rd_reg(a_pm(10, 0), d); check("R10 perm frozen", d, 32'h8000_0005);
    wr_reg(a_lo(10), 32'h999);
    rd_reg(a_lo(10), d); check("R10 start frozen", d, 32'h400);
    wr_reg(a_hi(10), 32'h999);
    rd_reg(a_hi(10), d); check("R10 end frozen", d, 32'h400);
    wr_reg(a_pm(10, 1), 32'h7);
    rd_reg(a_pm(10, 1), d); check("R10 group1 frozen", d, 0);
    probe(0, 1'b1, 1'b0, at_unit(32'h400), ok); check("R10 locked code applies", 32'(ok), 0);
    wr_reg(a_lo(11), 32'h123);
    rd_reg(a_lo(11), d); check("R10 other window free", d, 32'h123);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    rd_reg(a_pm(10, 0), d); check("R10 reset clears lock", d, 0);
    wr_reg(a_lo(10), 32'h42);
    rd_reg(a_lo(10), d); check("R10 writable after reset", d, 32'h42);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_map();
    t_outside();
    t_codes();
    t_domain();
    t_range();
    t_overlap();
    t_below();
    t_timing();
    t_same_cycle();
    t_lock();
    finish_run();
  end

  initial begin
    #500000;
    n_tests++;
    n_fail++;
    $display("FAIL watchdog R9 actual=timeout expected=completion");
    finish_run();
  end
endmodule